// File: doc/BRIEF.md
# External Bus Read/Write Strobe Generator

This block turns one bus request at a time into active-low strobes for an external memory bus. Each memory region is either 8 or 16 bits wide. A request carries its direction, its size (byte or word) and the lowest address bit. A flag that comes with each request gives the width of the region it targets. The block answers with a one-cycle strobe pulse, and then with a one-cycle completion pulse.

On a 16-bit region the strobes follow one of two encodings. The first is a shared write strobe plus a high-byte enable. The second is a separate low-byte write strobe and a separate high-byte write strobe. A mode register selects the encoding. That register accepts writes only while an unlock bit in a protect register is set. Accesses to 8-bit regions always use the shared-write encoding, whatever the mode bit holds.

Top module: `bus_strobe_gen`

## Requirements
- R1: After reset, all strobes (`bus_rd_n`, `bus_wlo_n`, `bus_hi_n`) are high and `req_ready` is 1. `done` and `err` are 0, and the shared-write/byte-enable encoding is active.
- R2: A config write with `cfg_sel`=0 targets the mode register, whose bit 2 selects separate write strobes. A config write with `cfg_sel`=1 targets the protect register. The mode register takes the write only if protect bit 1 is 1 at that time; otherwise the write has no effect on any later strobe.
- R3: On a 16-bit region with mode bit 0, `bus_a0` equals the request LSB. `bus_hi_n` is low for an odd byte or a word. `bus_rd_n` is low for a read and `bus_wlo_n` is low for a write.
- R4: On a 16-bit region with mode bit 1, a write holds `bus_rd_n` high. `bus_wlo_n` is low for an even byte or a word, and `bus_hi_n` is low for an odd byte or a word.
- R5: On a 16-bit region with mode bit 1, a read drives `bus_rd_n` low and keeps `bus_wlo_n` and `bus_hi_n` high.
- R6: On an 8-bit region, with either mode, `bus_hi_n` stays high and `bus_wlo_n` acts as the single write strobe. The word flag is ignored: one byte moves, at address LSB `bus_a0`.
- R7: `req_ready` is 1 only while idle. The strobes are active exactly in the cycle after the request is accepted. In the cycle after that they are high, `done` is 1 for one cycle and `req_ready` is 1 again.
- R8: Read and write strobes are never low together, and all strobes are high between bus cycles.
- R9: A word request at an odd address on a 16-bit region activates no strobe. It completes with `err`=1 in the same cycle as `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Config register write enable |
| cfg_sel | input | 1 | 0 = mode register, 1 = protect register |
| cfg_wdata | input | CFG_DW | Config write data |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word (two bytes), 0 = byte |
| req_a0 | input | 1 | Address bit 0 |
| req_wide | input | 1 | 1 = target region is 16 bits wide |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wlo_n | output | 1 | Shared or low-byte write strobe, active low |
| bus_hi_n | output | 1 | High-byte enable or high-byte write strobe, active low |
| bus_a0 | output | 1 | Address bit 0 driven to the bus |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal-request flag, valid with done |

## Verification
The assertions assume that request fields are stable while `req_valid` is high. They also assume that `cfg_wr` is a single-cycle pulse with a defined select, and that at most one request is in flight. The stimulus meets these assumptions: it drives every input at the falling edge and offers a request only when `req_ready` is seen high. It drops `req_valid` right after acceptance, and it sends config writes only between bus cycles. Random requests cover all field combinations, including odd word requests and 8-bit regions. Random config writes flip the protect and mode bits, so both locked and unlocked writes occur while the bench tracks the expected mode.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef struct packed {
    logic rd_n;
    logic wlo_n;
    logic hi_n;
    logic a0;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{rd_n: 1'b1, wlo_n: 1'b1, hi_n: 1'b1, a0: 1'b0};

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} cyc_state_t;

  // Strobe encoding for one request; narrow regions ignore the mode bit.
  function automatic strobe_t encode_strobes(input logic write, input logic word,
                                             input logic a0, input logic wide,
                                             input logic sep);
    strobe_t s;
    s       = STROBE_IDLE;
    s.a0    = a0;
    s.rd_n  = write;
    if (!wide) begin
      s.wlo_n = !write;
      s.hi_n  = 1'b1;
    end else if (!sep) begin
      s.wlo_n = !write;
      s.hi_n  = !(word || a0);
    end else begin
      s.wlo_n = !(write && (word || !a0));
      s.hi_n  = !(write && (word || a0));
    end
    return s;
  endfunction

  function automatic logic is_illegal(input logic word, input logic a0, input logic wide);
    return wide && word && a0;
  endfunction

endpackage

// File: rtl/bsg_cfg_regs.sv
module bsg_cfg_regs #(
  parameter int DW         = 8,
  parameter int MODE_BIT   = 2,
  parameter int UNLOCK_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic          sep_mode
);
  logic [DW-1:0] mode_q, prot_q;
  logic          unlocked, mode_we, prot_we;

  assign unlocked = prot_q[UNLOCK_BIT];
  assign mode_we  = cfg_wr && !cfg_sel && unlocked;
  assign prot_we  = cfg_wr && cfg_sel;
  assign sep_mode = mode_q[MODE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      prot_q <= '0;
    end else begin
      if (mode_we) mode_q <= cfg_wdata;
      if (prot_we) prot_q <= cfg_wdata;
    end
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && !prot_q[UNLOCK_BIT]) |=> $stable(mode_q)); // R2
  AST_MODE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && prot_q[UNLOCK_BIT]) |=> (sep_mode == $past(cfg_wdata[MODE_BIT]))); // R2
endmodule

// File: rtl/bsg_decode.sv
module bsg_decode
  import bsg_pkg::*;
(
  input  logic    write,
  input  logic    word,
  input  logic    a0,
  input  logic    wide,
  input  logic    sep,
  output strobe_t strb,
  output logic    bad
);
  assign bad  = is_illegal(word, a0, wide);
  assign strb = bad ? STROBE_IDLE : encode_strobes(write, word, a0, wide, sep);

  always_comb begin
    AST_DEC_ONE_DIR: assert (strb.rd_n || strb.wlo_n); // R8
  end
endmodule

// File: rtl/bsg_cycle.sv
module bsg_cycle
  import bsg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  output logic    req_ready,
  input  logic    req_wide,
  input  strobe_t dec_strb,
  input  logic    dec_bad,
  output strobe_t bus_strb,
  output logic    done,
  output logic    err
);
  cyc_state_t state_q;
  strobe_t    strb_q;
  logic       bad_q, wide_q, done_q, err_q;
  logic       accept, strobing;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign bus_strb  = strb_q;
  assign done      = done_q;
  assign err       = err_q;
  assign strobing  = !strb_q.rd_n || !strb_q.wlo_n || !strb_q.hi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      strb_q  <= STROBE_IDLE;
      bad_q   <= 1'b0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (state_q == ST_BUSY) begin
        state_q <= ST_IDLE;
        strb_q  <= STROBE_IDLE;
        done_q  <= 1'b1;
        err_q   <= bad_q;
      end else if (accept) begin
        state_q <= ST_BUSY;
        strb_q  <= dec_strb;
        bad_q   <= dec_bad;
        wide_q  <= req_wide;
      end
    end
  end

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(!strb_q.rd_n && !strb_q.wlo_n)); // R8
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobing |=> !strobing); // R7
  AST_ACCEPT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready ##1 (done && req_ready)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !strobing); // R8
  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && bad_q) |-> !strobing); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R9
  AST_NARROW_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && !wide_q) |-> strb_q.hi_n); // R6
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int CFG_DW     = 8,
  parameter int MODE_BIT   = 2,
  parameter int UNLOCK_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_a0,
  input  logic              req_wide,
  output logic              bus_rd_n,
  output logic              bus_wlo_n,
  output logic              bus_hi_n,
  output logic              bus_a0,
  output logic              done,
  output logic              err
);
  logic    sep_mode, dec_bad;
  strobe_t dec_strb, bus_strb;

  bsg_cfg_regs #(.DW(CFG_DW), .MODE_BIT(MODE_BIT), .UNLOCK_BIT(UNLOCK_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sep_mode(sep_mode));

  bsg_decode u_dec (
    .write(req_write), .word(req_word), .a0(req_a0), .wide(req_wide),
    .sep(sep_mode), .strb(dec_strb), .bad(dec_bad));

  bsg_cycle u_cyc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wide(req_wide), .dec_strb(dec_strb), .dec_bad(dec_bad),
    .bus_strb(bus_strb), .done(done), .err(err));

  assign bus_rd_n  = bus_strb.rd_n;
  assign bus_wlo_n = bus_strb.wlo_n;
  assign bus_hi_n  = bus_strb.hi_n;
  assign bus_a0    = bus_strb.a0;
endmodule

// File: tb/sim_bus_strobe_gen.sv
module sim_bus_strobe_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = '0;
  logic req_valid = 0, req_write = 0, req_word = 0, req_a0 = 0, req_wide = 0;
  logic req_ready, bus_rd_n, bus_wlo_n, bus_hi_n, bus_a0, done, err;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit m_sep = 0, m_unlock = 0;

  always #10 clk = ~clk;

  bus_strobe_gen u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {rd,wlo,hi,a0} in the strobe cycle
  function automatic logic [3:0] expect_strb(bit w, bit wd, bit a, bit wide, bit sep);
    if (wide && wd && a) return 4'b1110;           // R9 no strobes
    if (!wide) return {w, !w, 1'b1, a};            // R6
    if (!sep)  return {w, !w, !(wd || a), a};      // R3
    if (!w)    return {1'b0, 1'b1, 1'b1, a};       // R5
    return {1'b1, !(wd || !a), !(wd || a), a};     // R4
  endfunction

  task automatic cfg(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    if (sel) m_unlock = d[1];
    else if (m_unlock) m_sep = d[2];
  endtask

  task automatic access(input string tag, input bit w, input bit wd, input bit a, input bit wide);
    logic [3:0] e;
    e = expect_strb(w, wd, a, wide, m_sep);
    @(negedge clk);
    chk({tag, " R7 ready idle"}, {7'd0, req_ready}, 8'd1);
    req_valid = 1; req_write = w; req_word = wd; req_a0 = a; req_wide = wide;
    @(negedge clk);
    req_valid = 0;
    chk(tag, {4'd0, bus_rd_n, bus_wlo_n, bus_hi_n, bus_a0}, {4'd0, e});
    chk({tag, " R7 busy"}, {6'd0, req_ready, done}, 8'd0);
    @(negedge clk);
    chk({tag, " R7/R9 done"}, {3'd0, bus_rd_n, bus_wlo_n, bus_hi_n, done, err},
        {3'd0, 3'b111, 1'b1, (wide && wd && a) ? 1'b1 : 1'b0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset", {2'd0, req_ready, bus_rd_n, bus_wlo_n, bus_hi_n, done, err}, 8'b0011_1100);
    rst_n = 1;
    @(negedge clk);
    // R1 default compat mode: odd byte write shows byte enable with shared write
    access("R1 default mode", 1, 0, 1, 1);
    // R2 locked write to the mode register is ignored
    cfg(0, 8'h04);
    access("R2 locked", 1, 0, 1, 1);
    chk("R2 locked wlo low", {7'd0, m_sep}, 8'd0);
    cfg(1, 8'h02);
    cfg(0, 8'h04);
    access("R4 odd write", 1, 0, 1, 1);
    access("R4 even write", 1, 0, 0, 1);
    access("R4 word write", 1, 1, 0, 1);
    access("R5 read", 0, 1, 0, 1);
    access("R6 narrow in sep mode", 1, 1, 1, 0);
    access("R9 odd word", 0, 1, 1, 1);
    cfg(1, 8'h00);
    cfg(0, 8'h00);              // ignored, sep stays 1
    access("R2 relock", 1, 0, 0, 1);
    cfg(1, 8'h02);
    cfg(0, 8'h00);
    access("R3 word read", 0, 1, 0, 1);
    access("R3 even write", 1, 0, 0, 1);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0)
        cfg($urandom_range(0, 1) == 1, 8'($urandom));
      access("R3/R4/R5/R6/R8/R9 random", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule